// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block looks up the translation of one virtual page in a hashed page table held in memory. A requester presents a hash value, a table base and mask, a segment page-size encoding, a flag saying whether 64K pages are available, and the abbreviated virtual page number that an entry must carry. On a start pulse the block captures these values. It then walks the primary group of eight entries one doubleword at a time over a simple request/response memory port. If no entry in the primary group is accepted, it walks the secondary group, which is addressed by the complemented hash.

An entry is accepted when it is valid, its secondary-hash flag matches the pass being searched, and its compare field matches. Its second doubleword must also carry a size code that suits the segment's page size. Entries that fail the size test are skipped and the walk continues. The block ends with a one-cycle done pulse carrying either hit or miss. On a hit it also returns the byte offset of the accepted entry from the table base and both of that entry's doublewords.

Top module: `hpt_group_search`

## Requirements
- R1: An entry is a candidate only when first-doubleword bit 0 (valid) is 1, bit 1 (secondary flag) equals the pass (0 primary, 1 secondary), and bits 63:7 equal `cmp_val`.
- R2: With a 4K segment size, every candidate is accepted.
- R3: With a 64K segment size, a candidate is accepted only when bits 15:12 of its second doubleword equal 4'h1.
- R4: With a 16M segment size, a candidate is accepted only when bits 19:12 of its second doubleword are all zero.
- R5: `seg_enc` 9'h000 selects 4K, 9'h100 selects 16M, and 9'h110 selects 64K only while `cap_64k` is 1. Any other encoding, including 9'h110 with `cap_64k` at 0, selects no size, and every entry is then skipped.
- R6: The primary group at byte offset ((hash & mask) << 7) from `tbl_base` is searched first. The secondary group at ((~hash & mask) << 7) is searched only after the whole primary group fails.
- R7: Entries inside a group are examined in index order 0 to 7, each 16 bytes long, and the first accepted one ends the search. `hit_offset` is the group offset plus 16 times the index, and `hit_dw0`/`hit_dw1` carry its two doublewords.
- R8: Done is a one-cycle pulse with exactly one of hit or miss. On a miss, `hit_offset` is all ones and both doubleword outputs are zero.
- R9: Each read request carries one doubleword address and is held stable until `rd_req_ready`. Only one read is outstanding at a time. The first doubleword is at the entry address and the second is 8 bytes above it. The second doubleword is fetched only for a candidate under a selected size.
- R10: `start` is sampled only while the block is idle. A start during a search changes neither the result nor the number of done pulses.
- R11: After reset the block is idle, with no read request and done, hit and miss low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (sampled when idle) |
| hash | input | HASH_W | Hash value for the primary group |
| tbl_base | input | ADDR_W | Byte address of the table |
| tbl_mask | input | HASH_W | Mask applied to the hash |
| seg_enc | input | 9 | Segment page-size encoding |
| cap_64k | input | 1 | 64K page size available |
| cmp_val | input | DW-7 | Compare value for entry bits 63:7 |
| rd_req_valid | output | 1 | Read request |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | ADDR_W | Doubleword byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DW | Read data |
| done | output | 1 | Search finished (one cycle) |
| hit | output | 1 | Entry accepted |
| miss | output | 1 | No entry accepted |
| hit_offset | output | ADDR_W | Byte offset of accepted entry, all ones on miss |
| hit_dw0 | output | DW | First doubleword of accepted entry |
| hit_dw1 | output | DW | Second doubleword of accepted entry |

## Verification
The bench builds the block with a 3-bit hash and a 16-bit address space, so the whole table is eight groups of eight entries. Every hash value, every segment encoding class and both capability settings can then be swept against several pseudo-random table fills, each with full and with reduced masks. That small configuration puts secondary-pass searches, skipped size codes, double misses and fetch counts all within reach. A bench model computes the expected entry and read counts for each case. Directed cases pin first-wins ordering, the complemented-hash secondary group and starts issued while the block is busy.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the hashed page table searcher.
// Assumes 9-bit segment encodings and fixed entry field positions.
package hpt_pkg;

    typedef enum logic [1:0] {
        PSZ_NONE = 2'd0,
        PSZ_4K   = 2'd1,
        PSZ_64K  = 2'd2,
        PSZ_16M  = 2'd3
    } psz_t;

    localparam int SEG_ENC_W = 9;
    localparam logic [SEG_ENC_W-1:0] SEG_ENC_4K  = 9'h000;
    localparam logic [SEG_ENC_W-1:0] SEG_ENC_16M = 9'h100;
    localparam logic [SEG_ENC_W-1:0] SEG_ENC_64K = 9'h110;

    // first doubleword: bit0 valid, bit1 secondary flag, compare field from CMP_LSB up
    localparam int CMP_LSB = 7;
    // second doubleword: size field bits 19:12
    localparam int SZ_LSB  = 12;
    localparam int SZ_W    = 8;
    localparam logic [3:0] SZ64K_CODE = 4'h1;

endpackage

// File: rtl/hpt_psize_decode.sv
`timescale 1ns/1ps
// Decodes the segment page-size encoding into a size class.
// Assumes the 64K encoding is only honoured when the capability is set.
module hpt_psize_decode
    import hpt_pkg::*;
(
    input  logic [SEG_ENC_W-1:0] seg_enc,
    input  logic                 cap_64k,
    output psz_t                 psz
);

    // map encoding to size class
    always_comb begin
        if (seg_enc == SEG_ENC_4K)
            psz = PSZ_4K;
        else if (seg_enc == SEG_ENC_16M)
            psz = PSZ_16M;
        else if (seg_enc == SEG_ENC_64K && cap_64k)
            psz = PSZ_64K;
        else
            psz = PSZ_NONE;
    end

endmodule

// File: rtl/hpt_entry_match.sv
`timescale 1ns/1ps
// Qualifies one table entry: candidate test on the first doubleword fields,
// and acceptance once the size field of the second doubleword is known.
// Assumes the size field input is only meaningful when accept is used.
module hpt_entry_match
    import hpt_pkg::*;
#(
    parameter int CMP_W = 57
) (
    input  logic             e_valid,
    input  logic             e_sec,
    input  logic [CMP_W-1:0] e_cmp,
    input  logic [SZ_W-1:0]  e_size,
    input  logic             pass,
    input  logic [CMP_W-1:0] cmp_val,
    input  psz_t             psz,
    output logic             cand,
    output logic             accept
);

    logic size_ok;

    // candidate test: valid, correct pass, compare match, size selected
    always_comb begin
        cand = e_valid && (e_sec == pass) && (e_cmp == cmp_val) && (psz != PSZ_NONE);
    end

    // size field test for the segment page size
    always_comb begin
        case (psz)
            PSZ_4K:  size_ok = 1'b1;
            PSZ_64K: size_ok = (e_size[3:0] == SZ64K_CODE);
            PSZ_16M: size_ok = (e_size == '0);
            default: size_ok = 1'b0;
        endcase
    end

    // final acceptance
    always_comb begin
        accept = cand && size_ok;
    end

endmodule

// File: rtl/hpt_group_addr.sv
`timescale 1ns/1ps
// Forms the entry offset and doubleword address for a pass and index.
// Assumes ADDR_W >= HASH_W and that the group size is a power of two.
module hpt_group_addr #(
    parameter int HASH_W      = 39,
    parameter int ADDR_W      = 64,
    parameter int IDX_W       = 3,
    parameter int ENTRY_SHIFT = 4,
    parameter int DW_BYTES    = 8
) (
    input  logic [HASH_W-1:0] hash,
    input  logic [HASH_W-1:0] mask,
    input  logic [ADDR_W-1:0] base,
    input  logic              pass,
    input  logic [IDX_W-1:0]  idx,
    input  logic              upper,
    output logic [ADDR_W-1:0] entry_off,
    output logic [ADDR_W-1:0] entry_addr
);

    localparam int GROUP_SHIFT = IDX_W + ENTRY_SHIFT;

    logic [HASH_W-1:0] grp_sel;

    // pick the hash for this pass and mask it
    always_comb begin
        grp_sel = (pass ? ~hash : hash) & mask;
    end

    // entry offset from table base and doubleword address
    always_comb begin
        entry_off  = (ADDR_W'(grp_sel) << GROUP_SHIFT) + (ADDR_W'(idx) << ENTRY_SHIFT);
        entry_addr = base + entry_off + (upper ? ADDR_W'(DW_BYTES) : '0);
    end

endmodule

// File: rtl/hpt_group_search.sv
`timescale 1ns/1ps
// Hashed page table group searcher. Walks the primary group, then the
// secondary group, one doubleword per read, until an entry is accepted.
// Assumes one outstanding read and a response only for an accepted request.
module hpt_group_search
    import hpt_pkg::*;
#(
    parameter int HASH_W        = 39,
    parameter int ADDR_W        = 64,
    parameter int DW            = 64,
    parameter int GROUP_ENTRIES = 8,
    localparam int CMP_W        = DW - CMP_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [HASH_W-1:0]    hash,
    input  logic [ADDR_W-1:0]    tbl_base,
    input  logic [HASH_W-1:0]    tbl_mask,
    input  logic [SEG_ENC_W-1:0] seg_enc,
    input  logic                 cap_64k,
    input  logic [CMP_W-1:0]     cmp_val,
    output logic                 rd_req_valid,
    input  logic                 rd_req_ready,
    output logic [ADDR_W-1:0]    rd_req_addr,
    input  logic                 rd_rsp_valid,
    input  logic [DW-1:0]        rd_rsp_data,
    output logic                 done,
    output logic                 hit,
    output logic                 miss,
    output logic [ADDR_W-1:0]    hit_offset,
    output logic [DW-1:0]        hit_dw0,
    output logic [DW-1:0]        hit_dw1
);

    localparam int IDX_W       = $clog2(GROUP_ENTRIES);
    localparam int DW_BYTES    = DW / 8;
    localparam int ENTRY_SHIFT = $clog2(2 * DW_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_W0, S_RD1, S_W1
    } st_t;

    st_t               state;
    logic              pass_q;
    logic [IDX_W-1:0]  idx_q;
    logic [HASH_W-1:0] hash_q;
    logic [HASH_W-1:0] mask_q;
    logic [ADDR_W-1:0] base_q;
    logic [CMP_W-1:0]  cmp_q;
    psz_t              psz_q;
    psz_t              psz_in;
    logic [DW-1:0]     dw0_q;
    logic [DW-1:0]     dw0_src;
    logic [ADDR_W-1:0] entry_off;
    logic [ADDR_W-1:0] entry_addr;
    logic              cand;
    logic              accept;
    logic              step;
    logic              last_idx;

    hpt_psize_decode u_dec (
        .seg_enc (seg_enc),
        .cap_64k (cap_64k),
        .psz     (psz_in)
    );

    hpt_group_addr #(
        .HASH_W      (HASH_W),
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT),
        .DW_BYTES    (DW_BYTES)
    ) u_addr (
        .hash       (hash_q),
        .mask       (mask_q),
        .base       (base_q),
        .pass       (pass_q),
        .idx        (idx_q),
        .upper      (state == S_RD1),
        .entry_off  (entry_off),
        .entry_addr (entry_addr)
    );

    // first doubleword comes from the bus while it arrives, else from the capture
    always_comb begin
        dw0_src = (state == S_W0) ? rd_rsp_data : dw0_q;
    end

    hpt_entry_match #(
        .CMP_W (CMP_W)
    ) u_match (
        .e_valid (dw0_src[0]),
        .e_sec   (dw0_src[1]),
        .e_cmp   (dw0_src[DW-1:CMP_LSB]),
        .e_size  (rd_rsp_data[SZ_LSB +: SZ_W]),
        .pass    (pass_q),
        .cmp_val (cmp_q),
        .psz     (psz_q),
        .cand    (cand),
        .accept  (accept)
    );

    // read request driven from the request states
    always_comb begin
        rd_req_valid = (state == S_RD0) || (state == S_RD1);
        rd_req_addr  = entry_addr;
    end

    // entry rejected: move on to the next entry, pass, or finish
    always_comb begin
        step = rd_rsp_valid &&
               (((state == S_W0) && !cand) || ((state == S_W1) && !accept));
        last_idx = (idx_q == LAST_IDX);
    end

    // search sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            pass_q     <= 1'b0;
            idx_q      <= '0;
            hash_q     <= '0;
            mask_q     <= '0;
            base_q     <= '0;
            cmp_q      <= '0;
            psz_q      <= PSZ_NONE;
            dw0_q      <= '0;
            done       <= 1'b0;
            hit        <= 1'b0;
            miss       <= 1'b0;
            hit_offset <= '0;
            hit_dw0    <= '0;
            hit_dw1    <= '0;
        end else begin
            done <= 1'b0;
            hit  <= 1'b0;
            miss <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        hash_q <= hash;
                        mask_q <= tbl_mask;
                        base_q <= tbl_base;
                        cmp_q  <= cmp_val;
                        psz_q  <= psz_in;
                        pass_q <= 1'b0;
                        idx_q  <= '0;
                        state  <= S_RD0;
                    end
                end
                S_RD0: begin
                    if (rd_req_ready) state <= S_W0;
                end
                S_W0: begin
                    if (rd_rsp_valid) begin
                        dw0_q <= rd_rsp_data;
                        if (cand) state <= S_RD1;
                    end
                end
                S_RD1: begin
                    if (rd_req_ready) state <= S_W1;
                end
                S_W1: begin
                    if (rd_rsp_valid && accept) begin
                        done       <= 1'b1;
                        hit        <= 1'b1;
                        hit_offset <= entry_off;
                        hit_dw0    <= dw0_q;
                        hit_dw1    <= rd_rsp_data;
                        state      <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
            if (step) begin
                if (!last_idx) begin
                    idx_q <= idx_q + 1'b1;
                    state <= S_RD0;
                end else if (!pass_q) begin
                    pass_q <= 1'b1;
                    idx_q  <= '0;
                    state  <= S_RD0;
                end else begin
                    done       <= 1'b1;
                    miss       <= 1'b1;
                    hit_offset <= '1;
                    hit_dw0    <= '0;
                    hit_dw1    <= '0;
                    state      <= S_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/hpt_group_search_chk.sv
`timescale 1ns/1ps
// Protocol and result checker for the group searcher, bound to the top.
// Assumes the result outputs are only interpreted while done is high.
module hpt_group_search_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              done,
    input logic              hit,
    input logic              miss,
    input logic [ADDR_W-1:0] hit_offset,
    input logic              hit_valid_bit
);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({hit, miss}));

    p_flags_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss) |-> done);

    p_miss_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (&hit_offset));

    p_hit_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_valid_bit);

    p_hit_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_offset[3:0] == 4'h0));

    p_quiet_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req_valid);

endmodule

bind hpt_group_search hpt_group_search_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_addr   (rd_req_addr),
    .done          (done),
    .hit           (hit),
    .miss          (miss),
    .hit_offset    (hit_offset),
    .hit_valid_bit (hit_dw0[0])
);

// File: tb/hpt_group_search_test.sv
`timescale 1ns/1ps
// Sweep bench for the group searcher in a small configuration.
module hpt_group_search_test;

    localparam int HASH_W = 3;
    localparam int ADDR_W = 16;
    localparam int DW     = 64;
    localparam int CMP_W  = 57;
    localparam logic [15:0] BASE = 16'h1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        hash = '0;
    logic [15:0]       tbl_base = BASE;
    logic [2:0]        tbl_mask = 3'h7;
    logic [8:0]        seg_enc = '0;
    logic              cap_64k = 1'b0;
    logic [CMP_W-1:0]  cmp_val = '0;
    logic              rd_req_valid;
    logic              rd_req_ready;
    logic [15:0]       rd_req_addr;
    logic              rd_rsp_valid;
    logic [63:0]       rd_rsp_data;
    logic              done, hit, miss;
    logic [15:0]       hit_offset;
    logic [63:0]       hit_dw0, hit_dw1;

    logic [63:0] mem [0:127];
    int   nchk = 0, nerr = 0, cyc = 0;
    int   n_rd0 = 0, n_rd1 = 0, n_oor = 0;
    bit   first_seen = 1'b0;
    logic [15:0] first_addr = '0;
    bit   stall = 1'b0;

    bit          exp_hit;
    logic [15:0] exp_off;
    logic [63:0] exp_dw0, exp_dw1;
    int          exp_rd0, exp_rd1;

    always #2.5 clk = ~clk;

    hpt_group_search #(
        .HASH_W(HASH_W), .ADDR_W(ADDR_W), .DW(DW), .GROUP_ENTRIES(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .hash(hash),
        .tbl_base(tbl_base), .tbl_mask(tbl_mask), .seg_enc(seg_enc),
        .cap_64k(cap_64k), .cmp_val(cmp_val),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .done(done), .hit(hit), .miss(miss),
        .hit_offset(hit_offset), .hit_dw0(hit_dw0), .hit_dw1(hit_dw1)
    );

    // memory responder: one-cycle latency, optional ready stalls
    initial begin
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        forever begin
            @(posedge clk);
            if (rd_req_valid && rd_req_ready) begin
                int w;
                w = int'((rd_req_addr - BASE) >> 3);
                if (w < 0 || w > 127) n_oor++;
                rd_rsp_valid <= 1'b1;
                rd_rsp_data  <= mem[w[6:0]];
                if (rd_req_addr[3]) n_rd1++; else n_rd0++;
                if (!first_seen) begin
                    first_addr = rd_req_addr;
                    first_seen = 1'b1;
                end
            end else begin
                rd_rsp_valid <= 1'b0;
            end
            rd_req_ready <= stall ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                nchk++; nerr++;
                $display("FAIL R11 watchdog: actual %0d cycles expected below %0d", cyc, 190000);
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input int unsigned a, input int unsigned b);
        logic [31:0] x;
        x = (a * 32'h9E3779B1) ^ (b * 32'h85EBCA6B) ^ 32'h01234567;
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        x = x * 32'h297A2D39;
        x = x ^ (x >> 15);
        return x;
    endfunction

    function automatic logic [63:0] mk_dw0(input bit v, input bit s, input logic [CMP_W-1:0] c);
        return {c, 5'b0, s, v};
    endfunction

    function automatic logic [CMP_W-1:0] cmp_for(input int s);
        return {25'h1ABCDEF, 32'h12345678} ^ CMP_W'(s);
    endfunction

    // pseudo-random table fill for scenario s
    task automatic fill(input int s);
        for (int e = 0; e < 64; e++) begin
            logic [31:0] r, r2;
            logic [7:0]  sz;
            logic [CMP_W-1:0] c;
            r  = mix(e, s);
            r2 = mix(e + 1000, s);
            c  = (r[4:3] == 2'b00) ? cmp_for(s) : (cmp_for(s) ^ CMP_W'({r[7:5], 1'b1}));
            case (r[10:8])
                3'd0: sz = 8'h00; 3'd1: sz = 8'h01; 3'd2: sz = 8'h10;
                3'd3: sz = 8'h11; 3'd4: sz = 8'h21; 3'd5: sz = 8'h00;
                3'd6: sz = 8'h31; default: sz = 8'h01;
            endcase
            mem[2*e]     = mk_dw0(r[0] | r[1], r[2], c);
            mem[2*e + 1] = {r2, r[31:20], sz, r[11:0]};
        end
    endtask

    // reference search computed from the requirements
    task automatic model(input logic [2:0] h, input logic [2:0] m, input logic [8:0] enc,
                         input bit cap, input logic [CMP_W-1:0] cv);
        int psz;
        psz = (enc == 9'h000) ? 1 : (enc == 9'h100) ? 3 : ((enc == 9'h110) && cap) ? 2 : 0;
        exp_hit = 1'b0; exp_off = 16'hFFFF; exp_dw0 = '0; exp_dw1 = '0;
        exp_rd0 = 0; exp_rd1 = 0;
        for (int p = 0; p < 2 && !exp_hit; p++) begin
            for (int i = 0; i < 8 && !exp_hit; i++) begin
                logic [2:0]  g;
                int          w;
                logic [63:0] d0, d1;
                bit          ok;
                g  = ((p == 1) ? ~h : h) & m;
                w  = int'(g) * 16 + i * 2;
                d0 = mem[w];
                exp_rd0++;
                if (d0[0] && (d0[1] == p[0]) && (d0[63:7] == cv) && psz != 0) begin
                    exp_rd1++;
                    d1 = mem[w + 1];
                    ok = (psz == 1) || (psz == 2 && d1[15:12] == 4'h1) ||
                         (psz == 3 && d1[19:12] == 8'h00);
                    if (ok) begin
                        exp_hit = 1'b1;
                        exp_off = 16'(g) * 16'd128 + 16'(i * 16);
                        exp_dw0 = d0;
                        exp_dw1 = d1;
                    end
                end
            end
        end
    endtask

    task automatic kick(input logic [2:0] h, input logic [2:0] m, input logic [8:0] enc,
                        input bit cap, input logic [CMP_W-1:0] cv);
        @(negedge clk);
        hash = h; tbl_mask = m; seg_enc = enc; cap_64k = cap; cmp_val = cv;
        n_rd0 = 0; n_rd1 = 0; first_seen = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic search(input logic [2:0] h, input logic [2:0] m, input logic [8:0] enc,
                          input bit cap, input logic [CMP_W-1:0] cv, input string rt);
        kick(h, m, enc, cap, cv);
        wait_done();
        model(h, m, enc, cap, cv);
        chk(done, {rt, " R8 done seen"}, 64'(done), 64'd1);
        chk(hit == exp_hit && miss == !exp_hit, {rt, " R1 R8 hit/miss"}, {hit, miss}, {exp_hit, !exp_hit});
        chk(hit_offset == exp_off, {rt, " R6 R7 offset"}, 64'(hit_offset), 64'(exp_off));
        chk(hit_dw0 == exp_dw0 && hit_dw1 == exp_dw1, {rt, " R7 doublewords"}, hit_dw1, exp_dw1);
        chk(n_rd0 == exp_rd0 && n_rd1 == exp_rd1, {rt, " R9 read counts"},
            64'(n_rd0 * 256 + n_rd1), 64'(exp_rd0 * 256 + exp_rd1));
        chk(first_addr == BASE + (16'(h & m) << 7), "R6 first read address",
            64'(first_addr), 64'(BASE + (16'(h & m) << 7)));
        @(negedge clk);
        chk(!done && !hit && !miss, "R8 single-cycle result", {done, hit, miss}, 64'd0);
    endtask

    initial begin
        logic [8:0] encs [4];
        encs[0] = 9'h000; encs[1] = 9'h100; encs[2] = 9'h110; encs[3] = 9'h050;

        repeat (4) @(negedge clk);
        chk(!done && !hit && !miss && !rd_req_valid, "R11 reset state",
            {done, hit, miss, rd_req_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rd_req_valid && !done, "R11 idle after reset", {rd_req_valid, done}, 64'd0);

        // directed: first accepted entry wins (R7)
        for (int k = 0; k < 128; k++) mem[k] = '0;
        mem[4*16 + 2*2] = mk_dw0(1'b1, 1'b0, cmp_for(0));
        mem[4*16 + 2*5] = mk_dw0(1'b1, 1'b0, cmp_for(0));
        kick(3'd4, 3'd7, 9'h000, 1'b0, cmp_for(0));
        wait_done();
        chk(hit && hit_offset == 16'h0220, "R7 first of two wins", 64'(hit_offset), 64'h220);
        chk(n_rd0 == 3 && n_rd1 == 1, "R9 fetches stop at hit", 64'(n_rd0 * 256 + n_rd1), 64'h301);

        // directed: secondary group uses complemented hash (R6), pass flag honoured (R1)
        for (int k = 0; k < 128; k++) mem[k] = '0;
        mem[4*16 + 2*1] = mk_dw0(1'b1, 1'b1, cmp_for(0));
        mem[3*16 + 2*0] = mk_dw0(1'b1, 1'b0, cmp_for(0));
        mem[3*16 + 2*6] = mk_dw0(1'b1, 1'b1, cmp_for(0));
        kick(3'd4, 3'd7, 9'h000, 1'b0, cmp_for(0));
        wait_done();
        chk(hit && hit_offset == 16'h01E0, "R6 secondary group hit", 64'(hit_offset), 64'h1E0);
        chk(n_rd0 == 15 && n_rd1 == 1, "R1 R9 wrong-pass entries not fetched",
            64'(n_rd0 * 256 + n_rd1), 64'hF01);

        // directed: 64K encoding without capability skips everything (R5)
        mem[4*16 + 2*0] = mk_dw0(1'b1, 1'b0, cmp_for(0));
        mem[4*16 + 2*0 + 1] = 64'h0000_0000_0000_1000;
        kick(3'd4, 3'd7, 9'h110, 1'b0, cmp_for(0));
        wait_done();
        chk(miss && hit_offset == 16'hFFFF, "R5 no capability gives miss", 64'(hit_offset), 64'hFFFF);
        kick(3'd4, 3'd7, 9'h110, 1'b1, cmp_for(0));
        wait_done();
        chk(hit && hit_offset == 16'h0200, "R3 64K code accepted", 64'(hit_offset), 64'h200);

        // sweep over fills, hashes, encodings and capability
        for (int s = 0; s < 6; s++) begin
            fill(s);
            stall = s[0];
            for (int h = 0; h < 8; h++) begin
                for (int e = 0; e < 4; e++) begin
                    for (int c = 0; c < 2; c++) begin
                        string rt;
                        case (e)
                            0: rt = "R2";
                            1: rt = "R4";
                            2: rt = (c == 1) ? "R3" : "R5";
                            default: rt = "R5";
                        endcase
                        search(3'(h), (s == 5) ? 3'd5 : 3'd7, encs[e], c[0], cmp_for(s), rt);
                    end
                end
            end
        end

        // start while busy is ignored (R10)
        fill(2);
        stall = 1'b1;
        kick(3'd2, 3'd7, 9'h000, 1'b0, cmp_for(2));
        repeat (3) @(negedge clk);
        hash = 3'd5; cmp_val = cmp_for(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        model(3'd2, 3'd7, 9'h000, 1'b0, cmp_for(2));
        chk(done && hit == exp_hit && hit_offset == exp_off, "R10 busy start ignored",
            64'(hit_offset), 64'(exp_off));
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk(extra == 0, "R10 no queued search", 64'(extra), 64'd0);
        end
        chk(n_oor == 0, "R9 reads inside table", 64'(n_oor), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule